// File: doc/BRIEF.md
# Programmable Interval Timer Channel with Target and Wrap Interrupts

One 16-bit up-counter channel behind a small register bus. Software programs a compare value and a control word. The counter then advances on every cycle in which the external tick enable is high. It signals when the count lands on the compare value, or when it rolls from the top value back to zero. The control word can make the counter restart from zero when it hits the compare value. It also selects which of the two events may interrupt, whether the interrupt may repeat or happens only once per programming, and whether the request bit pulses or toggles.

The request bit in the control word is active-low: 1 means armed and 0 means fired. A one-clock `irq_o` strobe marks every fall of that bit. The target-reached and wrap-reached status bits are sticky, and reading the control word clears them. Clock-source selection, gating and the system interrupt controller sit outside this block.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count and compare registers read 0x0000, the control word reads 0x0400 and `irq_o` is low.
- R2: The count rises by one at each clock edge where `tick_i` is high and holds otherwise. A bus write to offset 0x0 loads the count.
- R3: On a tick at count 0xFFFF the count becomes 0x0000. If control bit 5 is set this fires an interrupt and sets sticky bit 12.
- R4: With control bit 6 clear (one-shot), only the first enabled target or wrap event fires. Later events leave bit 10, bits 11 and 12, and `irq_o` untouched until the next control write.
- R5: With control bit 3 set, the tick that would bring the count equal to the compare value loads 0x0000 instead.
- R6: With control bit 4 set, the count reaching the compare value fires an interrupt and sets sticky bit 11. With bit 3 clear the count runs on past the compare value.
- R7: With control bit 7 clear (pulse), a firing drives bit 10 to 0 and `irq_o` is high for exactly one cycle. With bit 6 also set, bit 10 returns to 1 after REL_CYC cycles (4 by default).
- R8: With control bit 7 set (toggle), each firing inverts bit 10. `irq_o` strobes only on a 1-to-0 change.
- R9: A read of offset 0x4 returns bits 11 and 12 as they stand and then clears them. A second read shows them as 0.
- R10: A write to offset 0x4 clears the count to zero, forces bit 10 to 1, clears bits 11 and 12 and forgets one-shot history.
- R11: A compare value written at or below the current count produces no target event until the count has wrapped.
- R12: The count is at offset 0x0, the control word at 0x4 and the compare value at 0x8. Other offsets read 0x0000 and ignore writes. In the control word only bits 3 to 7 are writable; bits 10 to 12 are status and read back as described above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after the strobe |
| tick_i | input | 1 | Count enable from the prescaler |
| irq_o | output | 1 | One-cycle strobe on each fall of control bit 10 |

## Verification
The hardest case to reach is the pulse-mode release window. Bit 10 must stay low for an exact number of cycles and then rise by itself. The count write and the tick must place the firing on a known edge. The bench then reads the control word back-to-back so that each read samples a consecutive cycle of the window. The wrap cases are reached by loading the count just under 0xFFFF instead of ticking through the whole range. The suppressed-target case loads a compare value behind the count and then ticks across a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_MODE = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_TGT  = 4'h8;

  // control word bit positions
  localparam int unsigned MB_RST_TGT = 3;
  localparam int unsigned MB_TGT_EN  = 4;
  localparam int unsigned MB_OVF_EN  = 5;
  localparam int unsigned MB_RPT     = 6;
  localparam int unsigned MB_TOGGLE  = 7;
  localparam int unsigned MB_IRQ_N   = 10;
  localparam int unsigned MB_TFLAG   = 11;
  localparam int unsigned MB_OFLAG   = 12;

  typedef struct packed {
    logic toggle;
    logic rpt;
    logic ovf_en;
    logic tgt_en;
    logic rst_tgt;
  } mode_ctl_t;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] tgt_i,
  input  logic         rst_on_tgt_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_inc;
  logic         adv;

  assign cnt_inc = cnt_q + 1'b1;
  assign adv     = tick_i & ~clr_i & ~ld_i;
  // equality on the advanced value: a compare behind the count waits for the wrap
  assign hit_o   = adv & (cnt_inc == tgt_i);
  assign wrap_o  = adv & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (ld_i)                   cnt_q <= ld_val_i;
    else if (adv) begin
      if (hit_o && rst_on_tgt_i)     cnt_q <= '0;
      else                           cnt_q <= cnt_inc;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned REL_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_wr_i,
  input  logic mode_rd_i,
  input  logic tgt_evt_i,
  input  logic ovf_evt_i,
  input  logic tgt_en_i,
  input  logic ovf_en_i,
  input  logic rpt_i,
  input  logic toggle_i,
  output logic irq_n_o,
  output logic tflag_o,
  output logic oflag_o,
  output logic fire_tgt_o,
  output logic fire_ovf_o,
  output logic irq_o
);
  localparam int unsigned REL_W = $clog2(REL_CYC + 1);

  logic             qual_t, qual_o, qual, fire;
  logic             irq_n_q, irq_n_d, once_q, tflag_q, oflag_q, irq_q;
  logic [REL_W-1:0] rel_q;
  logic             rel_done;

  assign qual_t = tgt_evt_i & tgt_en_i;
  assign qual_o = ovf_evt_i & ovf_en_i;
  assign qual   = qual_t | qual_o;
  assign fire   = qual & (rpt_i | ~once_q);

  assign fire_tgt_o = fire & qual_t;
  assign fire_ovf_o = fire & qual_o;

  generate
    if (REL_CYC > 0) begin : g_rel
      assign rel_done = (rel_q == REL_W'(1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          rel_q <= '0;
        else if (mode_wr_i)                   rel_q <= '0;
        else if (fire && !toggle_i && rpt_i)  rel_q <= REL_W'(REL_CYC);
        else if (rel_q != '0)                 rel_q <= rel_q - 1'b1;
      end
    end else begin : g_norel
      assign rel_done = 1'b0;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rel_q <= '0;
        else         rel_q <= '0;
      end
    end
  endgenerate

  always_comb begin
    irq_n_d = irq_n_q;
    if (mode_wr_i)     irq_n_d = 1'b1;
    else if (fire)     irq_n_d = toggle_i ? ~irq_n_q : 1'b0;
    else if (rel_done) irq_n_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_n_q <= 1'b1;
      once_q  <= 1'b0;
      tflag_q <= 1'b0;
      oflag_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_n_q <= irq_n_d;
      irq_q   <= irq_n_q & ~irq_n_d;
      if (mode_wr_i) begin
        once_q  <= 1'b0;
        tflag_q <= 1'b0;
        oflag_q <= 1'b0;
      end else begin
        if (qual) once_q <= 1'b1;
        // a set in the read cycle survives the clear
        tflag_q <= fire_tgt_o | (tflag_q & ~mode_rd_i);
        oflag_q <= fire_ovf_o | (oflag_q & ~mode_rd_i);
      end
    end
  end

  assign irq_n_o = irq_n_q;
  assign tflag_o = tflag_q;
  assign oflag_o = oflag_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REL_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  logic             cnt_wr, mode_wr, tgt_wr, mode_rd;
  mode_ctl_t        mode_q;
  logic [CNT_W-1:0] tgt_q, cnt, mode_rdv, rdata_q;
  logic             hit, wrap, irq_n, tflag, oflag, fire_tgt, fire_ovf;

  assign cnt_wr  = wr_en_i & (addr_i == OFS_CNT);
  assign mode_wr = wr_en_i & (addr_i == OFS_MODE);
  assign tgt_wr  = wr_en_i & (addr_i == OFS_TGT);
  assign mode_rd = rd_en_i & (addr_i == OFS_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      tgt_q  <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_ctl_t'(wdata_i[MB_TOGGLE:MB_RST_TGT]);
      if (tgt_wr)  tgt_q  <= wdata_i;
    end
  end

  tmr_count #(.W(CNT_W)) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .clr_i        (mode_wr),
    .ld_i         (cnt_wr),
    .ld_val_i     (wdata_i),
    .tgt_i        (tgt_q),
    .rst_on_tgt_i (mode_q.rst_tgt),
    .cnt_o        (cnt),
    .hit_o        (hit),
    .wrap_o       (wrap)
  );

  tmr_irq #(.REL_CYC(REL_CYC)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (mode_wr),
    .mode_rd_i  (mode_rd),
    .tgt_evt_i  (hit),
    .ovf_evt_i  (wrap),
    .tgt_en_i   (mode_q.tgt_en),
    .ovf_en_i   (mode_q.ovf_en),
    .rpt_i      (mode_q.rpt),
    .toggle_i   (mode_q.toggle),
    .irq_n_o    (irq_n),
    .tflag_o    (tflag),
    .oflag_o    (oflag),
    .fire_tgt_o (fire_tgt),
    .fire_ovf_o (fire_ovf),
    .irq_o      (irq_o)
  );

  always_comb begin
    mode_rdv                       = '0;
    mode_rdv[MB_TOGGLE:MB_RST_TGT] = mode_q;
    mode_rdv[MB_IRQ_N]             = irq_n;
    mode_rdv[MB_TFLAG]             = tflag;
    mode_rdv[MB_OFLAG]             = oflag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        OFS_CNT:  rdata_q <= cnt;
        OFS_MODE: rdata_q <= mode_rdv;
        OFS_TGT:  rdata_q <= tgt_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cnt_wr,
  input logic             mode_wr,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_n,
  input logic             irq_o,
  input logic             tflag,
  input logic             oflag,
  input logic             fire_tgt,
  input logic             fire_ovf,
  input logic             rpt
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (mode_wr) seen_q <= 1'b0;
    else if (irq_o)   seen_q <= 1'b1;
  end

  assert_mode_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (cnt == '0) && irq_n && !tflag && !oflag);

  assert_irq_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !irq_n && $past(irq_n));

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr && !mode_wr && (&cnt)) |=> (cnt == '0));

  assert_tflag_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tflag) |-> $past(fire_tgt));

  assert_oflag_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oflag) |-> $past(fire_ovf));

  assert_one_shot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !rpt) |-> !irq_o);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .cnt_wr   (cnt_wr),
  .mode_wr  (mode_wr),
  .cnt      (cnt),
  .irq_n    (irq_n),
  .irq_o    (irq_o),
  .tflag    (tflag),
  .oflag    (oflag),
  .fire_tgt (fire_tgt),
  .fire_ovf (fire_ovf),
  .rpt      (mode_q.rpt)
);

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
  localparam int NV = 42;
  localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_TK = 4'd2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  tmr_chan u_tmr_chan (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  // {op, req, addr, data, expected}
  localparam logic [43:0] VEC [NV] = '{
    {OP_RD, 4'd1,  4'h0, 16'h0000, 16'h0000}, // R1
    {OP_RD, 4'd1,  4'h4, 16'h0000, 16'h0400}, // R1
    {OP_RD, 4'd1,  4'h8, 16'h0000, 16'h0000}, // R1
    {OP_TK, 4'd2,  4'h0, 16'd5,    16'h0000},
    {OP_RD, 4'd2,  4'h0, 16'h0000, 16'h0005}, // R2
    {OP_WR, 4'd2,  4'h0, 16'h1234, 16'h0000},
    {OP_RD, 4'd2,  4'h0, 16'h0000, 16'h1234}, // R2
    {OP_WR, 4'd10, 4'h4, 16'h0058, 16'h0000},
    {OP_RD, 4'd10, 4'h0, 16'h0000, 16'h0000}, // R10
    {OP_RD, 4'd10, 4'h4, 16'h0000, 16'h0458}, // R10
    {OP_WR, 4'd5,  4'h8, 16'h0006, 16'h0000},
    {OP_TK, 4'd5,  4'h0, 16'd6,    16'h0000},
    {OP_RD, 4'd5,  4'h0, 16'h0000, 16'h0000}, // R5
    {OP_TK, 4'd5,  4'h0, 16'd3,    16'h0000},
    {OP_RD, 4'd5,  4'h0, 16'h0000, 16'h0003}, // R5
    {OP_RD, 4'd9,  4'h4, 16'h0000, 16'h0C58}, // R9 R6
    {OP_RD, 4'd9,  4'h4, 16'h0000, 16'h0458}, // R9
    {OP_WR, 4'd6,  4'h4, 16'h0050, 16'h0000},
    {OP_WR, 4'd6,  4'h8, 16'h0003, 16'h0000},
    {OP_TK, 4'd6,  4'h0, 16'd8,    16'h0000},
    {OP_RD, 4'd6,  4'h0, 16'h0000, 16'h0008}, // R6
    {OP_RD, 4'd6,  4'h4, 16'h0000, 16'h0C50}, // R6
    {OP_WR, 4'd3,  4'h4, 16'h0060, 16'h0000},
    {OP_WR, 4'd3,  4'h0, 16'hFFFE, 16'h0000},
    {OP_TK, 4'd3,  4'h0, 16'd8,    16'h0000},
    {OP_RD, 4'd3,  4'h0, 16'h0000, 16'h0006}, // R3
    {OP_RD, 4'd3,  4'h4, 16'h0000, 16'h1460}, // R3
    {OP_WR, 4'd11, 4'h4, 16'h0050, 16'h0000},
    {OP_WR, 4'd11, 4'h0, 16'h0100, 16'h0000},
    {OP_WR, 4'd11, 4'h8, 16'h0080, 16'h0000},
    {OP_TK, 4'd11, 4'h0, 16'd16,   16'h0000},
    {OP_RD, 4'd11, 4'h4, 16'h0000, 16'h0450}, // R11
    {OP_WR, 4'd11, 4'h0, 16'hFFF0, 16'h0000},
    {OP_TK, 4'd11, 4'h0, 16'hA0,   16'h0000},
    {OP_RD, 4'd11, 4'h0, 16'h0000, 16'h0090}, // R11
    {OP_RD, 4'd11, 4'h4, 16'h0000, 16'h0C50}, // R11
    {OP_WR, 4'd12, 4'hC, 16'hBEEF, 16'h0000},
    {OP_RD, 4'd12, 4'hC, 16'h0000, 16'h0000}, // R12
    {OP_RD, 4'd12, 4'h0, 16'h0000, 16'h0090}, // R12
    {OP_WR, 4'd12, 4'h4, 16'h1C50, 16'h0000},
    {OP_RD, 4'd12, 4'h4, 16'h0000, 16'h0450}, // R12
    {OP_RD, 4'd12, 4'h8, 16'h0000, 16'h0080}  // R12
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_tick(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    logic [15:0] pexp [5];
    repeat (3) @(negedge clk);
    check("R1 irq_o", {15'd0, irq}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][43:40])
        OP_WR: bus_wr(VEC[i][35:32], VEC[i][31:16]);
        OP_TK: do_tick(int'(VEC[i][31:16]));
        default: begin
          bus_rd(VEC[i][35:32], d);
          check($sformatf("R%0d vec%0d", VEC[i][39:36], i), d, VEC[i][15:0]);
        end
      endcase
    end

    // R7 pulse repeat: one-cycle strobe and exact release window
    pexp = '{16'h0858, 16'h0058, 16'h0058, 16'h0058, 16'h0458};
    bus_wr(4'h4, 16'h0058);
    bus_wr(4'h8, 16'h0002);
    do_tick(2);
    check("R7 irq_o strobe", {15'd0, irq}, 16'd1);
    for (int k = 0; k < 5; k++) begin
      bus_rd(4'h4, d);
      check($sformatf("R7 release cyc%0d", k), d, pexp[k]);
      if (k == 0) check("R7 irq_o one cycle", {15'd0, irq}, 16'd0);
    end

    // R8 toggle repeat with restart on target
    bus_wr(4'h4, 16'h00D8);
    bus_wr(4'h8, 16'h0002);
    do_tick(2);
    check("R8 first fire strobe", {15'd0, irq}, 16'd1);
    bus_rd(4'h4, d);
    check("R8 bit10 low", d, 16'h08D8);
    do_tick(2);
    check("R8 rise no strobe", {15'd0, irq}, 16'd0);
    bus_rd(4'h4, d);
    check("R8 bit10 high", d, 16'h0CD8);
    do_tick(2);
    check("R8 third fire strobe", {15'd0, irq}, 16'd1);

    // R4 one-shot pulse
    bus_wr(4'h4, 16'h0018);
    bus_wr(4'h8, 16'h0002);
    do_tick(2);
    check("R4 first fires", {15'd0, irq}, 16'd1);
    bus_rd(4'h4, d);
    check("R4 after first", d, 16'h0818);
    do_tick(2);
    check("R4 second ignored", {15'd0, irq}, 16'd0);
    bus_rd(4'h4, d);
    check("R4 no flag, still low", d, 16'h0018);
    bus_wr(4'h4, 16'h0018);
    do_tick(2);
    check("R10 rewrite rearms", {15'd0, irq}, 16'd1);

    // R1 reset mid-run
    bus_wr(4'h0, 16'h1234);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 irq_o in reset", {15'd0, irq}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    bus_rd(4'h0, d);
    check("R1 count after reset", d, 16'h0000);
    bus_rd(4'h4, d);
    check("R1 mode after reset", d, 16'h0400);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule